// File: doc/BRIEF.md
# SDRAM Per-Bank State Tracker

This block sits on the controller side of a multi-bank SDRAM interface. It follows every command the controller places on the bus. For each bank it keeps a state machine: idle, open, bursting, precharging or refreshing. Each command is judged against the current bank states and the per-bank timing counters. The block then reports whether the command was accepted or illegal. An illegal command leaves all tracked state untouched. The block also counts the auto-refresh commands it accepts.

The controller presents one decoded command per clock, along with a bank index and the auto-precharge / all-banks address bit. The verdict for the command sampled at a rising edge appears on `cmdOk` / `cmdIllegal` right after that edge, and the bank states update at the same edge. The row-to-column delay, the minimum open time, the precharge time, the refresh time and the burst length are all parameters counted in clock cycles. Data paths and the memory array are outside the block.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads idle (state code 0, packed 3 bits per bank with bank b at bits 3b+2..3b), both verdict outputs are 0 and the refresh count is 0. State codes: 0 idle, 1 open, 2 reading, 3 writing, 4 precharging, 5 refreshing. Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst-stop, 6 auto-refresh, 7 mode-set.
- R2: One cycle after a command, `cmdOk` is 1 if the command was legal and was not a no-op, and `cmdIllegal` is 1 if it was illegal. The two are never high together. A no-op raises neither. An illegal command changes no bank state and no count.
- R3: Activate is legal only on an idle bank, which then becomes open. Activate on any other bank state is illegal.
- R4: Read or write is legal only if at least T_RCD cycles have passed since that bank's activate, and only if the bank is open or is in a burst with no auto-precharge pending.
- R5: A legal read (write) with address bit 10 low puts the bank in the reading (writing) state for BURST_LEN cycles. After that the bank returns to open.
- R6: A legal read or write with address bit 10 high makes the bank go straight from its burst into precharging. While that is pending, a further read or write to the bank is illegal.
- R7: Precharge with bit 10 low applies to the addressed bank only. On an open, reading or writing bank it is illegal before T_RAS cycles since activate, and otherwise moves the bank to precharging. On an idle or precharging bank it is legal and has no effect.
- R8: Precharge with bit 10 high moves every open, reading or writing bank to precharging. It is illegal if any such bank has not reached T_RAS cycles since its activate.
- R9: A bank stays in the precharging state for exactly T_RP cycles and then becomes idle.
- R10: Burst-stop on a reading bank is legal and returns it to open. On a writing bank, or on a bank in any other state, it is illegal.
- R11: Auto-refresh is legal only when all banks are idle. All banks are then refreshing for T_RFC cycles. While any bank is refreshing, every command other than no-op is illegal.
- R12: Each legal auto-refresh adds one to the refresh count. The count saturates at REF_MAX.
- R13: Mode-set is legal only when all banks are idle and changes no bank state.
- R14: A command addressed to one bank leaves the other banks' states unchanged, except for an all-bank precharge or an auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Decoded command code (see R1) |
| bankAddr | input | BANK_W | Target bank index |
| addrBit10 | input | 1 | Auto-precharge on read/write; all banks on precharge |
| bankState | output | 3*NUM_BANKS | Packed per-bank state codes |
| cmdOk | output | 1 | Previous command was legal and not a no-op |
| cmdIllegal | output | 1 | Previous command was illegal |
| refreshCount | output | CNT_W | Saturating count of accepted auto-refreshes |

## Verification
The bound checker watches several things on every cycle. The two verdicts never coincide, and a no-op never produces a verdict. Activate on a busy bank, burst-stop during a write, a mode-set with any bank busy, and any command during refresh are always rejected. A precharging bank only ever stays precharging or turns idle, and a saturated refresh count stays put. Some behaviour spans many cycles, and only the bench's directed scenarios, compared against a behavioural model each clock, can show it. That covers the exact T_RCD and T_RAS boundaries, the burst length, auto-precharge chaining into precharge, the T_RP and T_RFC durations, all-bank precharge, and isolation between banks.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_BST  = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MODE = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPEN    = 3'd1,
    BK_READ    = 3'd2,
    BK_WRITE   = 3'd3,
    BK_PRECHG  = 3'd4,
    BK_REFRESH = 3'd5
  } bank_e;

  // strobes from the legality control to the bank datapath
  typedef struct packed {
    logic doAct;
    logic doRd;
    logic doWr;
    logic doPreOne;
    logic doPreAll;
    logic doBst;
    logic doRef;
    logic autoPre;
  } strobe_t;

  function automatic logic isOpen(input bank_e s);
    return (s == BK_OPEN) || (s == BK_READ) || (s == BK_WRITE);
  endfunction

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             cmd,
  input  logic [BANK_W-1:0]      bankAddr,
  input  logic                   addrBit10,
  input  logic [NUM_BANKS*3-1:0] bankSt,
  input  logic [NUM_BANKS-1:0]   rcdOk,
  input  logic [NUM_BANKS-1:0]   rasOk,
  input  logic [NUM_BANKS-1:0]   apPend,
  output strobe_t                strobe,
  output logic                   cmdOk,
  output logic                   cmdIllegal
);

  bank_e stArr [NUM_BANKS];
  cmd_e  curCmd;
  bank_e tgt;
  logic  anyRef, allIdle, rasAllOk, legal;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_unpack
    assign stArr[gb] = bank_e'(bankSt[gb*3 +: 3]);
  end

  assign curCmd = cmd_e'(cmd);
  assign tgt    = stArr[bankAddr];

  always_comb begin
    anyRef   = 1'b0;
    allIdle  = 1'b1;
    rasAllOk = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stArr[b] == BK_REFRESH) anyRef = 1'b1;
      if (stArr[b] != BK_IDLE) allIdle = 1'b0;
      if (isOpen(stArr[b]) && !rasOk[b]) rasAllOk = 1'b0;
    end
  end

  always_comb begin
    case (curCmd)
      CMD_NOP:        legal = 1'b1;
      CMD_ACT:        legal = (tgt == BK_IDLE);
      CMD_RD, CMD_WR: legal = rcdOk[bankAddr] &&
                              ((tgt == BK_OPEN) ||
                               (((tgt == BK_READ) || (tgt == BK_WRITE)) && !apPend[bankAddr]));
      CMD_PRE:        legal = addrBit10 ? rasAllOk : (!isOpen(tgt) || rasOk[bankAddr]);
      CMD_BST:        legal = (tgt == BK_READ);
      default:        legal = allIdle;  // refresh and mode-set
    endcase
    if (anyRef && (curCmd != CMD_NOP)) legal = 1'b0;
  end

  always_comb begin
    strobe          = '0;
    strobe.doAct    = legal && (curCmd == CMD_ACT);
    strobe.doRd     = legal && (curCmd == CMD_RD);
    strobe.doWr     = legal && (curCmd == CMD_WR);
    strobe.doPreOne = legal && (curCmd == CMD_PRE) && !addrBit10;
    strobe.doPreAll = legal && (curCmd == CMD_PRE) && addrBit10;
    strobe.doBst    = legal && (curCmd == CMD_BST);
    strobe.doRef    = legal && (curCmd == CMD_REF);
    strobe.autoPre  = addrBit10;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOk      <= 1'b0;
      cmdIllegal <= 1'b0;
    end else begin
      cmdOk      <= legal && (curCmd != CMD_NOP);
      cmdIllegal <= !legal;
    end
  end

endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int BURST_LEN = 4,
  parameter int REF_MAX   = 8192,
  parameter int CNT_W     = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [BANK_W-1:0]      bankAddr,
  output logic [NUM_BANKS*3-1:0] bankSt,
  output logic [NUM_BANKS-1:0]   rcdOk,
  output logic [NUM_BANKS-1:0]   rasOk,
  output logic [NUM_BANKS-1:0]   apPend,
  output logic [CNT_W-1:0]       refreshCount
);

  localparam int AGE_MAX = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int TMR_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BEAT_W  = $clog2(BURST_LEN + 1);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    bank_e             st;
    logic [AGE_W-1:0]  age;
    logic [TMR_W-1:0]  tmr;
    logic [BEAT_W-1:0] beat;
    logic              ap;
    logic              sel;

    assign sel = (bankAddr == BANK_W'(gb));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        age <= '0;
      end else if (strobe.doAct && sel) begin
        age <= AGE_W'(1);
      end else if ((age != '0) && (age < AGE_W'(AGE_MAX))) begin
        age <= age + AGE_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st   <= BK_IDLE;
        tmr  <= '0;
        beat <= '0;
        ap   <= 1'b0;
      end else if (strobe.doAct && sel) begin
        st <= BK_OPEN;
      end else if ((strobe.doRd || strobe.doWr) && sel) begin
        st   <= strobe.doRd ? BK_READ : BK_WRITE;
        beat <= '0;
        ap   <= strobe.autoPre;
      end else if (strobe.doBst && sel) begin
        st <= BK_OPEN;
        ap <= 1'b0;
      end else if ((strobe.doPreAll || (strobe.doPreOne && sel)) && isOpen(st)) begin
        st  <= BK_PRECHG;
        tmr <= TMR_W'(T_RP - 1);
        ap  <= 1'b0;
      end else if (strobe.doRef) begin
        st  <= BK_REFRESH;
        tmr <= TMR_W'(T_RFC - 1);
      end else begin
        case (st)
          BK_READ, BK_WRITE: begin
            if (beat == BEAT_W'(BURST_LEN - 1)) begin
              st  <= ap ? BK_PRECHG : BK_OPEN;
              tmr <= TMR_W'(T_RP - 1);
              ap  <= 1'b0;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
          BK_PRECHG, BK_REFRESH: begin
            if (tmr == '0) st <= BK_IDLE;
            else tmr <= tmr - TMR_W'(1);
          end
          default: ;
        endcase
      end
    end

    assign bankSt[gb*3 +: 3] = st;
    assign rcdOk[gb]         = (age >= AGE_W'(T_RCD));
    assign rasOk[gb]         = (age >= AGE_W'(T_RAS));
    assign apPend[gb]        = ap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshCount <= '0;
    end else if (strobe.doRef && (refreshCount != CNT_W'(REF_MAX))) begin
      refreshCount <= refreshCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int BURST_LEN = 4,
  parameter int REF_MAX   = 8192,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(REF_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             cmd,
  input  logic [BANK_W-1:0]      bankAddr,
  input  logic                   addrBit10,
  output logic [NUM_BANKS*3-1:0] bankState,
  output logic                   cmdOk,
  output logic                   cmdIllegal,
  output logic [CNT_W-1:0]       refreshCount
);

  strobe_t              strobe;
  logic [NUM_BANKS-1:0] rcdOk, rasOk, apPend;

  sdram_trk_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankAddr(bankAddr), .addrBit10(addrBit10),
    .bankSt(bankState), .rcdOk(rcdOk), .rasOk(rasOk), .apPend(apPend),
    .strobe(strobe), .cmdOk(cmdOk), .cmdIllegal(cmdIllegal)
  );

  sdram_trk_banks #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_RFC(T_RFC), .BURST_LEN(BURST_LEN), .REF_MAX(REF_MAX), .CNT_W(CNT_W)
  ) uBanks (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankAddr(bankAddr),
    .bankSt(bankState), .rcdOk(rcdOk), .rasOk(rasOk), .apPend(apPend),
    .refreshCount(refreshCount)
  );

endmodule

// File: rtl/sdram_trk_checker.sv
module sdram_trk_checker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REF_MAX   = 8192,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 14
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [2:0]             cmd,
  input logic [BANK_W-1:0]      bankAddr,
  input logic                   addrBit10,
  input logic [NUM_BANKS*3-1:0] bankState,
  input logic                   cmdOk,
  input logic                   cmdIllegal,
  input logic [CNT_W-1:0]       refreshCount
);

  logic [2:0] tgt;
  logic       anyRef, allIdle;

  assign tgt = bankState[int'(bankAddr)*3 +: 3];

  always_comb begin
    anyRef  = 1'b0;
    allIdle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankState[b*3 +: 3] == BK_REFRESH) anyRef = 1'b1;
      if (bankState[b*3 +: 3] != BK_IDLE) allIdle = 1'b0;
    end
  end

  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdOk && cmdIllegal));

  a_r2_nop_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP) |=> (!cmdOk && !cmdIllegal));

  a_r3_act_busy_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT && tgt != BK_IDLE) |=> cmdIllegal);

  a_r10_stop_in_write_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_BST && tgt == BK_WRITE) |=> cmdIllegal);

  a_r11_busy_during_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (anyRef && cmd != CMD_NOP) |=> cmdIllegal);

  a_r13_mode_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MODE && !allIdle) |=> cmdIllegal);

  a_r12_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCount == CNT_W'(REF_MAX)) |=> (refreshCount == CNT_W'(REF_MAX)));

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_pre
    a_r9_prechg_exit: assert property (@(posedge clk) disable iff (!rstN)
      (bankState[gb*3 +: 3] == BK_PRECHG) |=>
      ((bankState[gb*3 +: 3] == BK_PRECHG) || (bankState[gb*3 +: 3] == BK_IDLE)));
  end

endmodule

bind sdram_bank_tracker sdram_trk_checker #(
  .NUM_BANKS(NUM_BANKS), .REF_MAX(REF_MAX), .BANK_W(BANK_W), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .bankAddr(bankAddr), .addrBit10(addrBit10),
  .bankState(bankState), .cmdOk(cmdOk), .cmdIllegal(cmdIllegal),
  .refreshCount(refreshCount)
);

// File: tb/sdram_bank_tracker_test.sv
`timescale 1ns/1ps
module sdram_bank_tracker_test;

  localparam int NB   = 4;
  localparam int RCD  = 3;
  localparam int RAS  = 6;
  localparam int RP   = 3;
  localparam int RFC  = 4;
  localparam int BL   = 4;
  localparam int RMAX = 12;
  localparam int CW   = $clog2(RMAX + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2:0]      cmd = 3'd0;
  logic [1:0]      bankAddr = 2'd0;
  logic            addrBit10 = 1'b0;
  logic [NB*3-1:0] bankState;
  logic            cmdOk, cmdIllegal;
  logic [CW-1:0]   refreshCount;

  int testCount = 0;
  int failCount = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(NB), .T_RCD(RCD), .T_RAS(RAS), .T_RP(RP),
    .T_RFC(RFC), .BURST_LEN(BL), .REF_MAX(RMAX)) uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankAddr(bankAddr), .addrBit10(addrBit10),
    .bankState(bankState), .cmdOk(cmdOk), .cmdIllegal(cmdIllegal),
    .refreshCount(refreshCount));

  // ---------------- behavioural reference model ----------------
  int mSt[NB], mAge[NB], mBeat[NB], mTmr[NB];
  bit mAp[NB];
  bit mOk, mIll;
  int mRef;

  function automatic bit opn(input int s);
    return (s == 1) || (s == 2) || (s == 3);
  endfunction

  always @(posedge clk) begin
    int t;
    bit lg, anyR, allI, rasAll, hit;
    if (!rstN) begin
      foreach (mSt[b]) begin
        mSt[b] = 0; mAge[b] = 0; mBeat[b] = 0; mTmr[b] = 0; mAp[b] = 0;
      end
      mOk = 0; mIll = 0; mRef = 0;
    end else begin
      t = int'(bankAddr);
      anyR = 0; allI = 1; rasAll = 1;
      foreach (mSt[b]) begin
        if (mSt[b] == 5) anyR = 1;
        if (mSt[b] != 0) allI = 0;
        if (opn(mSt[b]) && mAge[b] < RAS) rasAll = 0;
      end
      case (cmd)
        3'd0: lg = 1;
        3'd1: lg = (mSt[t] == 0);
        3'd2, 3'd3: lg = (mAge[t] >= RCD) &&
                         (mSt[t] == 1 || ((mSt[t] == 2 || mSt[t] == 3) && !mAp[t]));
        3'd4: lg = addrBit10 ? rasAll : (!opn(mSt[t]) || mAge[t] >= RAS);
        3'd5: lg = (mSt[t] == 2);
        default: lg = allI;
      endcase
      if (anyR && cmd != 3'd0) lg = 0;
      mOk  = lg && (cmd != 3'd0);
      mIll = !lg;
      if (lg && cmd == 3'd6 && mRef < RMAX) mRef++;
      foreach (mSt[b]) begin
        hit = (b == t);
        if (mAge[b] > 0) mAge[b]++;
        if (lg && hit && cmd == 3'd1) begin
          mSt[b] = 1; mAge[b] = 1;
        end else if (lg && hit && (cmd == 3'd2 || cmd == 3'd3)) begin
          mSt[b] = int'(cmd); mBeat[b] = 0; mAp[b] = addrBit10;
        end else if (lg && hit && cmd == 3'd5) begin
          mSt[b] = 1; mAp[b] = 0;
        end else if (lg && cmd == 3'd4 && opn(mSt[b]) && (addrBit10 || hit)) begin
          mSt[b] = 4; mTmr[b] = RP; mAp[b] = 0;
        end else if (lg && cmd == 3'd6) begin
          mSt[b] = 5; mTmr[b] = RFC;
        end else if (mSt[b] == 2 || mSt[b] == 3) begin
          mBeat[b]++;
          if (mBeat[b] == BL) begin
            if (mAp[b]) begin mSt[b] = 4; mTmr[b] = RP; end
            else mSt[b] = 1;
            mAp[b] = 0;
          end
        end else if (mSt[b] == 4 || mSt[b] == 5) begin
          mTmr[b]--;
          if (mTmr[b] == 0) mSt[b] = 0;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic int stOf(input int b);
    return int'(bankState[b*3 +: 3]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int b = 0; b < NB; b++)
        check(stOf(b) == mSt[b], curReq, $sformatf("model bank%0d state", b), stOf(b), mSt[b]);
      check(cmdOk == mOk, curReq, "model cmdOk", int'(cmdOk), int'(mOk));
      check(cmdIllegal == mIll, curReq, "model cmdIllegal", int'(cmdIllegal), int'(mIll));
      check(int'(refreshCount) == mRef, curReq, "model refreshCount", int'(refreshCount), mRef);
    end
  end

  task automatic issue(input int c, input int b, input bit a10);
    cmd = 3'(c); bankAddr = 2'(b); addrBit10 = a10;
    @(negedge clk);
    cmd = 3'd0; bankAddr = 2'd0; addrBit10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic verdict(input string req, input bit expOk);
    check(cmdOk == expOk && cmdIllegal == !expOk, req,
          expOk ? "expected accept" : "expected illegal",
          int'({cmdOk, cmdIllegal}), expOk ? 2 : 1);
  endtask

  task automatic expSt(input string req, input int b, input int exp);
    check(stOf(b) == exp, req, $sformatf("bank%0d state", b), stOf(b), exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic runAll();
    idle(3);
    curReq = "R1";
    for (int b = 0; b < NB; b++) expSt("R1", b, 0);
    check(!cmdOk && !cmdIllegal, "R1", "verdicts in reset", int'({cmdOk, cmdIllegal}), 0);
    check(refreshCount == 0, "R1", "count in reset", int'(refreshCount), 0);
    rstN = 1'b1;
    idle(1);

    curReq = "R3";
    issue(1, 0, 0);  verdict("R3", 1); expSt("R3", 0, 1);
    expSt("R14", 1, 0);
    issue(1, 0, 0);  verdict("R3", 0); expSt("R2", 0, 1);
    curReq = "R4";
    issue(2, 0, 0);  verdict("R4", 0);               // only 2 cycles after activate
    issue(2, 0, 0);  verdict("R4", 1); expSt("R5", 0, 2);
    curReq = "R5";
    idle(BL - 1);    expSt("R5", 0, 2);
    idle(1);         expSt("R5", 0, 1);

    curReq = "R10";
    issue(3, 0, 0);  verdict("R4", 1); expSt("R5", 0, 3);
    issue(5, 0, 0);  verdict("R10", 0); expSt("R10", 0, 3);
    idle(BL);        expSt("R5", 0, 1);
    issue(2, 0, 0);  verdict("R10", 1);
    issue(5, 0, 0);  verdict("R10", 1); expSt("R10", 0, 1);
    issue(5, 0, 0);  verdict("R10", 0);

    curReq = "R6";
    issue(2, 0, 1);  verdict("R6", 1);
    issue(3, 0, 0);  verdict("R6", 0);
    idle(3);         expSt("R6", 0, 4);
    curReq = "R9";
    idle(2);         expSt("R9", 0, 4);
    idle(1);         expSt("R9", 0, 0);

    curReq = "R7";
    issue(4, 2, 0);  verdict("R7", 1); expSt("R7", 2, 0);
    issue(1, 1, 0);  verdict("R3", 1);
    issue(4, 1, 0);  verdict("R7", 0); expSt("R7", 1, 1);
    idle(4);
    issue(4, 1, 0);  verdict("R7", 1); expSt("R7", 1, 4);
    curReq = "R9";
    idle(2);         expSt("R9", 1, 4);
    idle(1);         expSt("R9", 1, 0);

    curReq = "R8";
    issue(1, 0, 0);  issue(1, 2, 0);
    issue(4, 3, 1);  verdict("R8", 0); expSt("R8", 0, 1); expSt("R8", 2, 1);
    idle(6);
    issue(4, 3, 1);  verdict("R8", 1);
    expSt("R8", 0, 4); expSt("R8", 2, 4); expSt("R14", 1, 0); expSt("R14", 3, 0);
    idle(3);

    curReq = "R13";
    issue(1, 3, 0);
    issue(7, 0, 0);  verdict("R13", 0); expSt("R13", 3, 1);
    curReq = "R11";
    issue(6, 0, 0);  verdict("R11", 0);
    check(refreshCount == 0, "R12", "illegal refresh not counted", int'(refreshCount), 0);
    idle(5);
    issue(4, 3, 0);  idle(RP);
    issue(7, 0, 0);  verdict("R13", 1); expSt("R13", 0, 0);
    issue(6, 2, 0);  verdict("R11", 1);
    for (int b = 0; b < NB; b++) expSt("R11", b, 5);
    check(refreshCount == 1, "R12", "count after refresh", int'(refreshCount), 1);
    issue(1, 1, 0);  verdict("R11", 0);
    issue(0, 0, 0);
    check(!cmdOk && !cmdIllegal, "R2", "no-op silent", int'({cmdOk, cmdIllegal}), 0);
    idle(RFC - 3);   expSt("R11", 0, 5);
    idle(1);         expSt("R11", 0, 0);

    curReq = "R12";
    for (int i = 0; i < RMAX + 2; i++) begin
      issue(6, 0, 0);
      idle(RFC);
    end
    check(int'(refreshCount) == RMAX, "R12", "saturated count", int'(refreshCount), RMAX);
    idle(2);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule